// File: doc/BRIEF.md
# Dual-Profile Carrier Phase Accumulator

This block produces the running carrier phase for a quadrature upconverter. Two profiles are held side by side. Each has a 26-bit tuning word and an 8-bit gain byte. A simple synchronous register bus loads each tuning word one byte at a time and loads each gain byte in one write. Every clock cycle the accumulator adds the tuning word of the active profile. Its output frequency is therefore the tuning word times the clock rate divided by 2^26.

The active profile comes from a control register bit ORed with an external select pin. A system uses one of the two sources and holds the other at zero. A one-cycle pulse marks each change of the effective profile, so that downstream gain logic can reload. A tuning word at or above 0x2000000 is never stored: the block clamps it to 0x1FFFFFF.

Top module: `dual_profile_phase_acc`

## Requirements
- R1: A synchronous active-high reset clears both tuning words, both gain bytes, the control bit, the selection and the accumulator. After reset the phase is 0, the gain output is 0 and the change pulse is low. The phase stays 0 until a tuning word is written.
- R2: On every clock edge outside reset, the phase advances by the active profile's tuning word, modulo 2^26.
- R3: Profile p (0 or 1) stores tuning-word byte k (0 = least significant) at address 0x10 + 4p + k. In byte 3, only data bits 1:0 are stored (tuning-word bits 25:24). Data bits 7:2 of byte 3 are ignored.
- R4: If a write would leave a tuning word with bit 25 set (a value of 0x2000000 or more), the stored word becomes 0x1FFFFFF.
- R5: A tuning-word byte written at clock edge t is used by the accumulation at edge t+1, with no staging.
- R6: The gain byte of profile p is written at address 0x18 + p. The gain output always shows the gain byte of the active profile.
- R7: The selection is bit 0 of the control register at address 0x00, ORed with the select pin. It is sampled on each clock edge. The value sampled at edge t picks the profile used for the phase step at edge t+1 and for the gain output after edge t.
- R8: The change pulse is high for the one cycle after each edge at which the sampled selection differs from its previous value. It is low otherwise, including when the bit and the pin are both 1 and only one of them drops.
- R9: Writes to any address other than 0x00, 0x10 to 0x17, 0x18 and 0x19 change no state.
- R10: Switching the profile changes both the phase step and the gain output together, and both profiles keep their own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| sel_pin | input | 1 | External profile select, ORed with the control bit |
| phase_o | output | 26 | Accumulated carrier phase |
| gain_o | output | 8 | Gain byte of the active profile |
| profile_changed_o | output | 1 | One-cycle pulse after the effective profile changes |

## Verification
Four properties hold on every cycle: the stored tuning words stay below the clamp limit, the sampled selection follows the OR of the control bit and the pin, the change pulse appears exactly when that selection toggles, and the phase holds still whenever the active step is zero. Three behaviours can only be shown by the bench's scenarios, which run against an arithmetic model: the byte-lane placement of each tuning-word write, the one-edge latency from a write to its use, and the values of wrapped phases. The same applies to unmapped writes being ignored and to each profile keeping its own contents across switches.

// File: rtl/dual_profile_phase_acc.sv
module dual_profile_phase_acc #(
  parameter int FTW_W     = 26,
  parameter int GAIN_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 0,
  parameter int FTW_BASE  = 16,
  parameter int GAIN_BASE = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sel_pin,
  output logic [FTW_W-1:0]  phase_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              profile_changed_o
);
  localparam int NPROF = 2;
  localparam int NB    = (FTW_W + 7) / 8;
  localparam logic [FTW_W-1:0] FTW_MAX = {1'b0, {(FTW_W-1){1'b1}}};

  logic [FTW_W-1:0]  ftw_w  [NPROF];
  logic [GAIN_W-1:0] gain_w [NPROF];
  logic              sel_bit_q;
  logic              sel_r;
  logic [FTW_W-1:0]  acc_q;

  wire ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    logic [FTW_W-1:0]  ftw_q;
    logic [GAIN_W-1:0] gain_q;
    logic [FTW_W-1:0]  merged;
    logic              hit;

    always_comb begin
      merged = ftw_q;
      hit    = 1'b0;
      for (int k = 0; k < NB; k++) begin
        if (wr_en && (wr_addr == ADDR_W'(FTW_BASE + p*NB + k))) begin
          hit = 1'b1;
          for (int b = 0; b < 8; b++)
            if (k*8 + b < FTW_W) merged[k*8 + b] = wr_data[b];
        end
      end
    end

    wire gain_hit = wr_en && (wr_addr == ADDR_W'(GAIN_BASE + p));

    always_ff @(posedge clk) begin
      if (rst) begin
        ftw_q  <= '0;
        gain_q <= '0;
      end else begin
        if (hit)      ftw_q  <= merged[FTW_W-1] ? FTW_MAX : merged;
        if (gain_hit) gain_q <= wr_data[GAIN_W-1:0];
      end
    end

    assign ftw_w[p]  = ftw_q;
    assign gain_w[p] = gain_q;
  end

  wire sel_now = sel_bit_q | sel_pin;
  wire [FTW_W-1:0] active_ftw = ftw_w[sel_r];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_bit_q         <= 1'b0;
      sel_r             <= 1'b0;
      profile_changed_o <= 1'b0;
      acc_q             <= '0;
    end else begin
      if (ctrl_hit) sel_bit_q <= wr_data[0];
      sel_r             <= sel_now;
      profile_changed_o <= sel_now ^ sel_r;
      acc_q             <= acc_q + active_ftw;
    end
  end

  assign phase_o = acc_q;
  assign gain_o  = gain_w[sel_r];

  // R4
  ftw_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !ftw_w[0][FTW_W-1] && !ftw_w[1][FTW_W-1]);

  // R7
  sel_track_chk: assert property (@(posedge clk) disable iff (rst)
    sel_r == $past(sel_bit_q | sel_pin));

  // R8
  change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    profile_changed_o == (sel_r != $past(sel_r)));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(active_ftw) == '0) |-> $stable(phase_o));
endmodule

// File: tb/dual_profile_phase_acc_tb.sv
`timescale 1ns/1ps
module dual_profile_phase_acc_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sel_pin = 1'b0;
  logic [25:0] phase_o;
  logic [7:0]  gain_o;
  logic        profile_changed_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dual_profile_phase_acc dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_pin(sel_pin), .phase_o(phase_o), .gain_o(gain_o),
    .profile_changed_o(profile_changed_o)
  );

  logic [25:0] m_ftw [2];
  logic [7:0]  m_gain [2];
  logic        m_bit, m_sel, m_chg;
  logic [25:0] m_phase;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ftw[0] = '0; m_ftw[1] = '0; m_gain[0] = '0; m_gain[1] = '0;
    m_bit = 1'b0; m_sel = 1'b0; m_chg = 1'b0; m_phase = '0;
  endtask

  task automatic model_edge(input logic we, input logic [4:0] a, input logic [7:0] d, input logic pin);
    logic ns;
    logic [31:0] w;
    int p, k;
    m_phase = m_phase + m_ftw[m_sel];
    ns = m_bit | pin;
    m_chg = (ns != m_sel);
    m_sel = ns;
    if (we) begin
      if (a == 5'h00) m_bit = d[0];
      else if (a >= 5'h10 && a <= 5'h17) begin
        p = (int'(a) - 16) / 4;
        k = (int'(a) - 16) % 4;
        w = {6'b0, m_ftw[p]};
        w[k*8 +: 8] = d;
        w[31:26] = '0;
        m_ftw[p] = w[25] ? 26'h1FF_FFFF : w[25:0];
      end else if (a == 5'h18) m_gain[0] = d;
      else if (a == 5'h19) m_gain[1] = d;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "phase R2", 32'(phase_o), 32'(m_phase));
    chk(tag, "gain R6", 32'(gain_o), 32'(m_gain[m_sel]));
    chk(tag, "changed R8", 32'(profile_changed_o), 32'(m_chg));
  endtask

  task automatic cyc(input string tag, input logic we, input logic [4:0] a, input logic [7:0] d, input logic pin);
    wr_en = we; wr_addr = a; wr_data = d; sel_pin = pin;
    @(negedge clk);
    model_edge(we, a, d, pin);
    compare(tag);
    wr_en = 1'b0;
  endtask

  task automatic idle(input string tag, input int n, input logic pin);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 5'h00, 8'h00, pin);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    rst = 1'b0;
    chk("R1", "phase", 32'(phase_o), 0);
    chk("R1", "gain", 32'(gain_o), 0);
    chk("R1", "changed", 32'(profile_changed_o), 0);
  endtask

  task automatic load_ftw(input string tag, input int p, input logic [25:0] v, input logic pin);
    for (int k = 0; k < 4; k++)
      cyc(tag, 1'b1, 5'(16 + 4*p + k), v[k*8 +: 8], pin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h5A; vals[3] = 8'hA5; vals[4] = 8'hFF;
    @(negedge clk);
    do_reset();
    idle("R1", 5, 1'b0);

    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++)
        for (int v = 0; v < 5; v++) begin
          cyc("R3/R5", 1'b1, 5'(16 + 4*p + k), vals[v], 1'(p));
          idle("R3/R5", 2, 1'(p));
        end

    load_ftw("R3", 0, 26'h0123456, 1'b0);
    cyc("R3", 1'b1, 5'h13, 8'hFC, 1'b0);
    idle("R3", 3, 1'b0);
    cyc("R4", 1'b1, 5'h13, 8'h02, 1'b0);
    idle("R4", 3, 1'b0);
    cyc("R4", 1'b1, 5'h17, 8'h03, 1'b0);
    idle("R4", 2, 1'b1);

    load_ftw("R2", 0, 26'h1FF_FFFF, 1'b0);
    idle("R2", 100, 1'b0);
    load_ftw("R2", 1, 26'h0000_003, 1'b0);
    idle("R2", 20, 1'b1);

    cyc("R6", 1'b1, 5'h18, 8'h3C, 1'b0);
    cyc("R6", 1'b1, 5'h19, 8'hC3, 1'b0);
    idle("R6", 2, 1'b0);
    idle("R10", 3, 1'b1);
    idle("R10", 3, 1'b0);

    cyc("R7", 1'b1, 5'h00, 8'h01, 1'b0);
    idle("R7", 3, 1'b0);
    idle("R8", 3, 1'b1);
    idle("R8", 2, 1'b0);
    cyc("R7", 1'b1, 5'h00, 8'hFE, 1'b0);
    idle("R8", 2, 1'b0);
    for (int i = 0; i < 8; i++) cyc("R8", 1'b0, 5'h00, 8'h00, 1'(i % 2));

    for (int a = 1; a < 32; a++)
      if (!(a >= 16 && a <= 25)) cyc("R9", 1'b1, 5'(a), 8'hFF, 1'b1);
    idle("R9", 3, 1'b1);
    idle("R10", 3, 1'b0);

    do_reset();
    idle("R1", 4, 1'b0);
    idle("R1", 2, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule